// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between an SDRAM command scheduler and the memory pins. Each cycle the scheduler may offer one command (ACTIVATE, READ, WRITE, PRECHARGE or NOP). Each command carries an internal bank index and a partition-pair select, and is offered over a valid/ready handshake. The block keeps per-bank state: whether the bank is open, and how many cycles have passed since its last ACTIVATE, PRECHARGE and WRITE. It withholds a command (ready low) until every spacing rule for the addressed bank is satisfied. It then drives the command onto registered issue outputs.

The spacing rules come from a 2-bit timing category configured per partition pair. The category selects a whole preset of row-precharge time, CAS latency, row-to-column delay, minimum row-active time and row-cycle time. Each pair also has a bank-count setting, either two or four internal banks. Commands that break the open/closed protocol, or that address a bank the pair does not have, are consumed at once. They are not issued, and they produce a one-cycle error pulse. Every issued READ is followed by a data-valid strobe after exactly the CAS latency of its pair. The block is clocked by the SDRAM clock, so all counts are SDRAM clock cycles. Configuration inputs are static while traffic flows.

Top module: `sdram_cmd_gate`

## Requirements
- R1: While reset is active and after its release with no traffic, `iss_cmd` is NOP (0), `err_pulse` and `rd_valid` are 0, and every bank is closed.
- R2: An ACTIVATE to a bank appears on the issue pins no earlier than tRP cycles after that bank's last PRECHARGE, and no earlier than tRC cycles after its last ACTIVATE. Category code (cfg_cat bits [2p+1:2p] for pair p) sets tRP/tRC: 00 gives 2/4, 01 gives 2/8, 10 gives 3/10, 11 gives 3/11.
- R3: A READ or WRITE appears no earlier than tRCD cycles after the bank's ACTIVATE. tRCD is 1, 2, 3 and 3 for categories 00, 01, 10 and 11.
- R4: A PRECHARGE appears no earlier than tRAS cycles after the bank's ACTIVATE, and no earlier than 2 cycles after its last WRITE. tRAS is 3, 5, 7 and 7 for categories 00, 01, 10 and 11.
- R5: An issued READ raises `rd_valid` for one cycle exactly CL cycles after the READ is on the issue pins. CL is 2 for categories 00/01 and 3 for 10/11.
- R6: When `cfg_four_bank[p]` is 0, a non-NOP command to pair p with bank 2 or 3 is accepted at once, is not issued, and pulses `err_pulse`. When the bit is 1, banks 0 to 3 are all usable.
- R7: An ACTIVATE to an open bank, or a READ, WRITE or PRECHARGE to a closed bank, is accepted at once regardless of timing, is not issued, and pulses `err_pulse` in the following cycle.
- R8: The two pairs use their own category, bank count and bank state independently.
- R9: While a valid request is held (ready low), the issue pins show NOP in the following cycle.
- R10: Command encoding is NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4; codes 5 to 7 behave as NOP. An accepted command appears on `iss_cmd`/`iss_bank`/`iss_pair` in the cycle after the handshake. A NOP request is always accepted and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cat | input | 2*NUM_PAIRS | Timing category per pair, pair p at [2p+1:2p] |
| cfg_four_bank | input | NUM_PAIRS | 1 = pair has four internal banks, 0 = two |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle (when valid) |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | log2(MAX_BANKS) | Internal bank index |
| req_pair | input | log2(NUM_PAIRS) | Partition-pair select |
| iss_cmd | output | 3 | Issued command code, NOP when idle |
| iss_bank | output | log2(MAX_BANKS) | Bank of the issued command |
| iss_pair | output | log2(NUM_PAIRS) | Pair of the issued command |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The bench drives back-to-back command sequences in all four categories, so each spacing limit is hit at its exact earliest cycle. A design off by one in any counter would release a command one cycle early or late, and the ready check or the issue cycle check would catch it. The bench places protocol violations inside a still-running timing window, to show that errors take precedence over the hold. A design that stalled them would leave ready low. It addresses the upper banks of a two-bank pair and then of a four-bank pair; a wrong bank-count decode would either issue an illegal command or reject a legal one. It mixes READs on pairs with CAS latency 2 and 3, so a strobe pipeline that ignored the per-pair latency would pulse in the wrong cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int TIM_W  = 4;
  localparam int MAX_CL = 3;

  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_ACT = 3'd1;
  localparam logic [2:0] CMD_RD  = 3'd2;
  localparam logic [2:0] CMD_WR  = 3'd3;
  localparam logic [2:0] CMD_PRE = 3'd4;

  typedef struct packed {
    logic [TIM_W-1:0] trp;
    logic [TIM_W-1:0] cl;
    logic [TIM_W-1:0] trcd;
    logic [TIM_W-1:0] tras;
    logic [TIM_W-1:0] trc;
  } timing_t;

  function automatic timing_t cat_timing(input logic [1:0] code);
    timing_t t;
    case (code)
      2'b00:   begin t.trp = 4'd2; t.cl = 4'd2; t.trcd = 4'd1; t.tras = 4'd3; t.trc = 4'd4;  end
      2'b01:   begin t.trp = 4'd2; t.cl = 4'd2; t.trcd = 4'd2; t.tras = 4'd5; t.trc = 4'd8;  end
      2'b10:   begin t.trp = 4'd3; t.cl = 4'd3; t.trcd = 4'd3; t.tras = 4'd7; t.trc = 4'd10; end
      default: begin t.trp = 4'd3; t.cl = 4'd3; t.trcd = 4'd3; t.tras = 4'd7; t.trc = 4'd11; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sdc_timing_lut.sv
module sdc_timing_lut
  import sdc_pkg::*;
#(
  parameter int NUM_PAIRS = 2
) (
  input  logic [2*NUM_PAIRS-1:0] cfg_cat,
  output timing_t                tim [NUM_PAIRS]
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign tim[p] = cat_timing(cfg_cat[2*p +: 2]);
  end

endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track
  import sdc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TWR   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TIM_W-1:0] trp,
  input  logic [TIM_W-1:0] trcd,
  input  logic [TIM_W-1:0] tras,
  input  logic [TIM_W-1:0] trc,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  output logic             is_open,
  output logic             act_ok,
  output logic             rdwr_ok,
  output logic             pre_ok
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TWR_C = CNT_W'(TWR);

  logic             open_d;
  logic [CNT_W-1:0] act_cnt, act_cnt_d;
  logic [CNT_W-1:0] pre_cnt, pre_cnt_d;
  logic [CNT_W-1:0] wr_cnt,  wr_cnt_d;
  logic             act_en, pre_en, wr_en;

  // counters advance until saturated; an event restarts them at 1
  always_comb begin
    act_en = do_act || (act_cnt != SAT);
    pre_en = do_pre || (pre_cnt != SAT);
    wr_en  = do_wr  || (wr_cnt  != SAT);
    act_cnt_d = do_act ? CNT_W'(1) : act_cnt + CNT_W'(1);
    pre_cnt_d = do_pre ? CNT_W'(1) : pre_cnt + CNT_W'(1);
    wr_cnt_d  = do_wr  ? CNT_W'(1) : wr_cnt  + CNT_W'(1);
    open_d = is_open;
    if (do_act)      open_d = 1'b1;
    else if (do_pre) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      act_cnt <= SAT;
      pre_cnt <= SAT;
      wr_cnt  <= SAT;
    end else begin
      is_open <= open_d;
      if (act_en) act_cnt <= act_cnt_d;
      if (pre_en) pre_cnt <= pre_cnt_d;
      if (wr_en)  wr_cnt  <= wr_cnt_d;
    end
  end

  assign act_ok  = (act_cnt >= CNT_W'(trc)) && (pre_cnt >= CNT_W'(trp));
  assign rdwr_ok = (act_cnt >= CNT_W'(trcd));
  assign pre_ok  = (act_cnt >= CNT_W'(tras)) && (wr_cnt >= TWR_C);

  // R7: column and precharge commands reach only an open bank
  a_r7_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd || do_wr || do_pre) |-> is_open);
  // R2: activate reaches only a closed bank and opens it
  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!is_open ##1 is_open));
  // R4: precharge closes the bank
  a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |=> !is_open);

endmodule

// File: rtl/sdc_read_strobe.sv
module sdc_read_strobe
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [TIM_W-1:0] cl,
  output logic             rd_valid
);

  localparam int SR_W = MAX_CL + 1;

  logic [SR_W-1:0] sr, sr_d;

  always_comb begin
    sr_d = sr >> 1;
    for (int i = 1; i < SR_W; i++) begin
      if (rd_fire && (cl == TIM_W'(i))) sr_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end

  assign rd_valid = sr[0];

  // R5: a strobe needs a read in flight one cycle before
  a_r5_strobe_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sr[1]));

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdc_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int MAX_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int TWR       = 2,
  localparam int PAIR_W   = $clog2(NUM_PAIRS),
  localparam int BANK_W   = $clog2(MAX_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_PAIRS-1:0] cfg_cat,
  input  logic [NUM_PAIRS-1:0]   cfg_four_bank,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_cmd,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [PAIR_W-1:0]      req_pair,
  output logic [2:0]             iss_cmd,
  output logic [BANK_W-1:0]      iss_bank,
  output logic [PAIR_W-1:0]      iss_pair,
  output logic                   err_pulse,
  output logic                   rd_valid
);

  localparam int TOT   = NUM_PAIRS * MAX_BANKS;
  localparam int IDX_W = PAIR_W + BANK_W;
  localparam int HALF  = MAX_BANKS / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  timing_t tim [NUM_PAIRS];
  timing_t sel;

  sdc_timing_lut #(.NUM_PAIRS(NUM_PAIRS)) u_lut (
    .cfg_cat (cfg_cat),
    .tim     (tim)
  );

  logic [TOT-1:0] open_v, act_ok_v, rdwr_ok_v, pre_ok_v;
  logic [IDX_W-1:0] idx;
  logic is_act, is_rd, is_wr, is_pre, known;
  logic bad_bank, proto_err, err_raw, tim_ok, fire;

  logic [2:0]        iss_cmd_d;
  logic [BANK_W-1:0] iss_bank_d;
  logic [PAIR_W-1:0] iss_pair_d;
  logic              err_d;

  always_comb begin
    sel    = tim[req_pair];
    idx    = {req_pair, req_bank};
    is_act = (req_cmd == CMD_ACT);
    is_rd  = (req_cmd == CMD_RD);
    is_wr  = (req_cmd == CMD_WR);
    is_pre = (req_cmd == CMD_PRE);
    known  = is_act | is_rd | is_wr | is_pre;

    bad_bank  = !cfg_four_bank[req_pair] && (req_bank >= BANK_W'(HALF));
    proto_err = is_act ? open_v[idx] : (known && !open_v[idx]);
    err_raw   = known && (bad_bank || proto_err);

    if (is_act)              tim_ok = act_ok_v[idx];
    else if (is_rd || is_wr) tim_ok = rdwr_ok_v[idx];
    else if (is_pre)         tim_ok = pre_ok_v[idx];
    else                     tim_ok = 1'b1;

    req_ready = !known || err_raw || tim_ok;
    fire      = req_valid && known && !err_raw && tim_ok;

    iss_cmd_d  = fire ? req_cmd  : CMD_NOP;
    iss_bank_d = fire ? req_bank : '0;
    iss_pair_d = fire ? req_pair : '0;
    err_d      = req_valid && err_raw;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      iss_cmd   <= CMD_NOP;
      iss_bank  <= '0;
      iss_pair  <= '0;
      err_pulse <= 1'b0;
    end else begin
      iss_cmd   <= iss_cmd_d;
      iss_bank  <= iss_bank_d;
      iss_pair  <= iss_pair_d;
      err_pulse <= err_d;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
      localparam int I = p * MAX_BANKS + b;
      logic hit;
      assign hit = fire && (req_pair == PAIR_W'(p)) && (req_bank == BANK_W'(b));

      sdc_bank_track #(.CNT_W(CNT_W), .TWR(TWR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .trp     (tim[p].trp),
        .trcd    (tim[p].trcd),
        .tras    (tim[p].tras),
        .trc     (tim[p].trc),
        .do_act  (hit && is_act),
        .do_rd   (hit && is_rd),
        .do_wr   (hit && is_wr),
        .do_pre  (hit && is_pre),
        .is_open (open_v[I]),
        .act_ok  (act_ok_v[I]),
        .rdwr_ok (rdwr_ok_v[I]),
        .pre_ok  (pre_ok_v[I])
      );
    end
  end

  sdc_read_strobe u_rd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_fire  (fire && is_rd),
    .cl       (sel.cl),
    .rd_valid (rd_valid)
  );

  // R9: a held request leaves the pins idle next cycle
  a_r9_held_nop: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !req_ready) |=> (iss_cmd == CMD_NOP));
  // R7: a rejected request never coincides with an issued command
  a_r7_err_no_issue: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_pulse |-> (iss_cmd == CMD_NOP));
  // R6: nothing reaches an upper bank of a two-bank pair
  a_r6_bank_limit: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((iss_cmd != CMD_NOP) && !cfg_four_bank[iss_pair]) |-> (iss_bank < BANK_W'(HALF)));

endmodule

// File: tb/sim_sdram_cmd_gate.sv
module sim_sdram_cmd_gate;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic       clk, rst_n;
  logic [3:0] cfg_cat;
  logic [1:0] cfg_four_bank;
  logic       req_valid, req_ready;
  logic [2:0] req_cmd;
  logic [1:0] req_bank;
  logic       req_pair;
  logic [2:0] iss_cmd;
  logic [1:0] iss_bank;
  logic       iss_pair;
  logic       err_pulse, rd_valid;

  sdram_cmd_gate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cat(cfg_cat), .cfg_four_bank(cfg_four_bank),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_pair(req_pair), .iss_cmd(iss_cmd),
    .iss_bank(iss_bank), .iss_pair(iss_pair), .err_pulse(err_pulse),
    .rd_valid(rd_valid)
  );

  typedef struct {
    bit    err;
    int    cmd;
    int    bank;
    int    pair;
    int    cyc;
    string tag;
  } item_t;

  item_t  exp_q[$];
  int     rd_q[$];
  int     checks = 0, failures = 0;
  int     cyc = 0;
  bit     done = 0;

  // requirement model state
  int last_act[2][4], last_pre[2][4], last_wr[2][4];
  bit open_m[2][4];

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int catv(input int p);
    return (cfg_cat >> (2*p)) & 3;
  endfunction
  function automatic int t_rp(input int c);   return (c < 2) ? 2 : 3; endfunction
  function automatic int t_cl(input int c);   return (c < 2) ? 2 : 3; endfunction
  function automatic int t_rcd(input int c);  return (c == 0) ? 1 : (c == 1) ? 2 : 3; endfunction
  function automatic int t_ras(input int c);  return (c == 0) ? 3 : (c == 1) ? 5 : 7; endfunction
  function automatic int t_rc(input int c);   return (c == 0) ? 4 : (c == 1) ? 8 : (c == 2) ? 10 : 11; endfunction
  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

  task automatic send(input int cmd, input int bank, input int pair, input string tag);
    bit known, err;
    int earliest, c, waited, pin;
    @(negedge clk);
    req_valid = 1; req_cmd = 3'(cmd); req_bank = 2'(bank); req_pair = 1'(pair);
    known = (cmd >= 1 && cmd <= 4);
    err = known && ((bank >= 2 && !cfg_four_bank[pair]) ||
                    ((cmd == 1) ? open_m[pair][bank] : !open_m[pair][bank]));
    earliest = 0;
    if (known && !err) begin
      case (cmd)
        1: earliest = imax(last_pre[pair][bank] + t_rp(catv(pair)),
                           last_act[pair][bank] + t_rc(catv(pair)));
        2, 3: earliest = last_act[pair][bank] + t_rcd(catv(pair));
        default: earliest = imax(last_act[pair][bank] + t_ras(catv(pair)),
                                 last_wr[pair][bank] + 2);
      endcase
    end
    waited = 0;
    forever begin
      #(Q);
      c = cyc;
      chk(req_ready == (!known || err || (c + 1 >= earliest)),
          {tag, " ready"}, req_ready, (!known || err || (c + 1 >= earliest)));
      if (waited > 0) chk(iss_cmd == 0, "R9 held request shows NOP", iss_cmd, 0);
      if (req_ready || waited > 40) break;
      @(negedge clk);
      waited++;
    end
    pin = c + 1;
    if (known) exp_q.push_back('{err: err, cmd: err ? 0 : cmd, bank: err ? 0 : bank,
                                 pair: err ? 0 : pair, cyc: pin, tag: tag});
    if (known && !err) begin
      case (cmd)
        1: begin open_m[pair][bank] = 1; last_act[pair][bank] = pin; end
        2: rd_q.push_back(pin + t_cl(catv(pair)));
        3: last_wr[pair][bank] = pin;
        default: begin open_m[pair][bank] = 0; last_pre[pair][bank] = pin; end
      endcase
    end
    @(posedge clk);
    #1 req_valid = 0; req_cmd = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (iss_cmd != 0 || err_pulse) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected output", int'(iss_cmd), 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(err_pulse == e.err, {e.tag, " err_pulse"}, err_pulse, e.err);
          chk(int'(iss_cmd) == e.cmd && int'(iss_bank) == e.bank && int'(iss_pair) == e.pair,
              {e.tag, " issued cmd/bank/pair"}, int'(iss_cmd)*100 + int'(iss_bank)*10 + int'(iss_pair),
              e.cmd*100 + e.bank*10 + e.pair);
          chk(cyc == e.cyc, {e.tag, " issue cycle"}, cyc, e.cyc);
        end
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R5 unexpected rd_valid", 1, 0);
        else begin
          int e;
          e = rd_q.pop_front();
          chk(cyc == e, "R5 rd_valid cycle", cyc, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 4; b++) begin
        last_act[p][b] = -1000; last_pre[p][b] = -1000; last_wr[p][b] = -1000; open_m[p][b] = 0;
      end
    rst_n = 0; req_valid = 0; req_cmd = 0; req_bank = 0; req_pair = 0;
    cfg_cat = 4'b01_00;        // pair0 cat 00, pair1 cat 01
    cfg_four_bank = 2'b01;     // pair0 four banks, pair1 two banks
    idle(3);
    #1;
    chk(iss_cmd == 0, "R1 reset iss_cmd", iss_cmd, 0);
    chk(err_pulse == 0, "R1 reset err_pulse", err_pulse, 0);
    chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);
    @(negedge clk); rst_n = 1;
    idle(4);
    #1;
    chk(iss_cmd == 0 && rd_valid == 0, "R1 idle after release", iss_cmd, 0);
    chk(req_ready == 1, "R1 idle ready", req_ready, 1);

    // category 00 on pair 0
    send(1, 0, 0, "R2 ACT p0b0");
    send(2, 0, 0, "R3 READ p0b0 tRCD1");
    send(3, 0, 0, "R3 WRITE p0b0");
    send(4, 0, 0, "R4 PRE p0b0 tRAS/tWR");
    send(1, 0, 0, "R2 ACT p0b0 tRP/tRC");
    send(1, 0, 0, "R7 ACT to open bank");
    send(2, 1, 0, "R7 READ to closed bank");
    send(4, 2, 0, "R7 PRE to closed bank");
    send(1, 2, 1, "R6 ACT bank2 on two-bank pair");
    send(1, 3, 0, "R6 ACT bank3 on four-bank pair");
    send(0, 0, 0, "R10 NOP request");
    send(6, 1, 0, "R10 unused code");
    // category 01 on pair 1, interleaved with pair 0
    send(1, 1, 1, "R8 ACT p1b1");
    send(2, 1, 1, "R3 READ p1b1 tRCD2");
    send(2, 0, 0, "R8 READ p0b0 CL2");
    send(4, 1, 1, "R4 PRE p1b1 tRAS5");
    send(1, 1, 1, "R2 ACT p1b1 tRC8");
    send(3, 1, 1, "R3 WRITE p1b1");
    send(4, 1, 1, "R4 PRE p1b1 tWR2");
    send(4, 0, 0, "R4 PRE p0b0");
    send(4, 3, 0, "R4 PRE p0b3");
    idle(20);

    // categories 10 and 11, pair 1 now four banks
    cfg_cat = 4'b11_10;
    cfg_four_bank = 2'b11;
    idle(2);
    send(1, 0, 0, "R2 ACT p0b0 cat10");
    send(2, 0, 0, "R3 READ p0b0 tRCD3");
    send(1, 3, 1, "R6 ACT p1b3 four-bank");
    send(2, 3, 1, "R5 READ p1b3 CL3");
    send(4, 0, 0, "R4 PRE p0b0 tRAS7");
    send(1, 0, 0, "R2 ACT p0b0 tRC10");
    send(4, 3, 1, "R4 PRE p1b3");
    send(1, 3, 1, "R2 ACT p1b3 tRC11");
    send(3, 3, 1, "R3 WRITE p1b3");
    send(4, 3, 1, "R4 PRE p1b3 after write");
    idle(12);
    chk(exp_q.size() == 0, "R10 all issues seen", exp_q.size(), 0);
    chk(rd_q.size() == 0, "R5 all strobes seen", rd_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule